// File: doc/BRIEF.md
# PHY Control Register Write Master

This block programs the receive-override register of every lane on two PHY instances through their parallel control-register ports. A single pulse on `start_i` sets the select line of both PHYs. The block then waits a fixed settling time and walks a built-in list of writes, first across the lanes of PHY 0 and then across the lanes of PHY 1. Each write is one four-phase request/acknowledge exchange.

Each write places its address and data on the target PHY's port one cycle before the write strobe is raised. The strobe stays high until that PHY's acknowledge is high and is then dropped. The write counts as finished once the acknowledge has fallen again. Each of the two acknowledge waits has its own cycle limit. When a limit runs out, the block raises a sticky warning flag for that phase and goes on as if the acknowledge had arrived. When the list is finished, `done_o` pulses for one cycle.

Top module: `phy_crw_master`

## Requirements
- R1: While reset is asserted and right after it is released, all selects, addresses, data, write strobes, `done_o` and both timeout flags are 0.
- R2: A `start_i` pulse seen while idle drives both selects to 1, and they stay 1 until reset. The first address appears on the (SETTLE_CYC+1)-th falling clock edge after the start cycle.
- R3: For each write, the address and data are already on the port, with the strobe low, during the cycle before the strobe rises.
- R4: The strobe stays high until the target acknowledge is sampled high and is low in the next cycle. The write finishes once the acknowledge is sampled low, and the next write's setup cycle follows at once.
- R5: Only the addressed PHY sees a nonzero address, nonzero data or a strobe. The other PHY's address, data and strobe stay 0.
- R6: The address of lane n is 0x1008 + 0x100*n, and the data is 0x0E21 (bits 0, 5, 9, 10 and 11 set).
- R7: Eight writes are issued in this order: lanes 0 to 3 on PHY 0 (port bits [15:0]), then lanes 0 to 3 on PHY 1 (port bits [31:16]).
- R8: If the acknowledge is still low after RISE_TMO_CYC cycles of strobe, the strobe drops, `rise_tmo_o` becomes 1 and the sequence continues.
- R9: If the acknowledge is still high after FALL_TMO_CYC cycles of waiting for it to fall, `fall_tmo_o` becomes 1 and the sequence continues.
- R10: `done_o` is high for exactly one cycle, right after the eighth write's acknowledge is seen low, and the block then returns to idle.
- R11: A `start_i` pulse that arrives while a sequence is running has no effect on the outputs.
- R12: Both timeout flags keep their value across later runs and are cleared only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts the write sequence when the block is idle |
| done_o | output | 1 | One-cycle pulse when the sequence has finished |
| phy_sel_o | output | N_PHY | Control-port select, one bit per PHY |
| phy_addr_o | output | N_PHY*AW | Register address per PHY; PHY p uses bits [p*AW +: AW] |
| phy_wdata_o | output | N_PHY*DW | Write data per PHY; same slicing as the address |
| phy_wen_o | output | N_PHY | Write strobe per PHY |
| phy_ack_i | input | N_PHY | Acknowledge per PHY |
| rise_tmo_o | output | 1 | Sticky flag: an acknowledge failed to rise in time |
| fall_tmo_o | output | 1 | Sticky flag: an acknowledge failed to fall in time |

## Verification
The write list runs with acknowledge delays that change from write to write, including zero-delay responses, so that stalling on the rise and stalling on the fall can each be seen on its own. A second run with all delays at zero checks the minimum cycle count per write. One write's acknowledge never rises and, in a separate run, one write's acknowledge stays high past its limit. This shows that the two flags are set separately, and that a stale high acknowledge carried into the next write is taken as that write's acknowledge. A start pulse during a running sequence and a rerun after a timeout show that the busy-start is ignored and that the flags are sticky.

// File: rtl/phy_crw_pkg.sv
package phy_crw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_SETTLE  = 3'd1,
      ST_SETUP   = 3'd2,
      ST_WAIT_HI = 3'd3,
      ST_WAIT_LO = 3'd4,
      ST_DONE    = 3'd5
   } crw_state_e;

endpackage

// File: rtl/crw_timer.sv
module crw_timer #(
   parameter int LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic expired_o
);
   localparam int CW = $clog2(LIMIT + 1);

   if (LIMIT < 1) begin : g_bad_limit
      $error("crw_timer: LIMIT must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cnt_q <= '0;
      else if (!run_i)                   cnt_q <= '0;
      else if (cnt_q != CW'(LIMIT - 1))  cnt_q <= cnt_q + 1'b1;
   end

   assign expired_o = run_i && (cnt_q == CW'(LIMIT - 1));

   p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      run_i |-> (cnt_q < CW'(LIMIT)));

endmodule

// File: rtl/crw_list.sv
module crw_list #(
   parameter int             N_PHY  = 2,
   parameter int             N_LANE = 4,
   parameter int             AW     = 16,
   parameter int             DW     = 16,
   parameter logic [AW-1:0]  BASE   = 16'h1008,
   parameter logic [AW-1:0]  STRIDE = 16'h0100,
   parameter logic [DW-1:0]  WVAL   = 16'h0E21,
   localparam int            PHY_W  = $clog2(N_PHY)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rewind_i,
   input  logic             step_i,
   output logic [PHY_W-1:0] phy_o,
   output logic [AW-1:0]    addr_o,
   output logic [DW-1:0]    data_o,
   output logic             last_o
);
   localparam int LANE_W = $clog2(N_LANE);
   localparam int IDX_W  = PHY_W + LANE_W;
   localparam int TOTAL  = N_PHY * N_LANE;

   if (N_LANE < 2 || (N_LANE & (N_LANE - 1)) != 0) begin : g_bad_lane
      $error("crw_list: N_LANE must be a power of two, at least 2");
   end
   if (N_PHY < 2 || (N_PHY & (N_PHY - 1)) != 0) begin : g_bad_phy
      $error("crw_list: N_PHY must be a power of two, at least 2");
   end
   if (AW <= LANE_W) begin : g_bad_aw
      $error("crw_list: AW too narrow for the lane index");
   end

   logic [IDX_W-1:0]  idx_q;
   logic [LANE_W-1:0] lane;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        idx_q <= '0;
      else if (rewind_i) idx_q <= '0;
      else if (step_i)   idx_q <= idx_q + 1'b1;
   end

   assign lane   = idx_q[LANE_W-1:0];
   assign phy_o  = idx_q[IDX_W-1:LANE_W];
   assign addr_o = BASE + (AW'(lane) * STRIDE);
   assign data_o = WVAL;
   assign last_o = (idx_q == IDX_W'(TOTAL - 1));

endmodule

// File: rtl/phy_crw_master.sv
module phy_crw_master #(
   parameter int             N_PHY        = 2,
   parameter int             N_LANE       = 4,
   parameter int             AW           = 16,
   parameter int             DW           = 16,
   parameter logic [AW-1:0]  LANE_BASE    = 16'h1008,
   parameter logic [AW-1:0]  LANE_STRIDE  = 16'h0100,
   parameter logic [DW-1:0]  WR_VALUE     = 16'h0E21,
   parameter int             SETTLE_CYC   = 10,
   parameter int             RISE_TMO_CYC = 500,
   parameter int             FALL_TMO_CYC = 500
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   output logic                done_o,
   output logic [N_PHY-1:0]    phy_sel_o,
   output logic [N_PHY*AW-1:0] phy_addr_o,
   output logic [N_PHY*DW-1:0] phy_wdata_o,
   output logic [N_PHY-1:0]    phy_wen_o,
   input  logic [N_PHY-1:0]    phy_ack_i,
   output logic                rise_tmo_o,
   output logic                fall_tmo_o
);
   import phy_crw_pkg::*;

   localparam int PHY_W = $clog2(N_PHY);

   crw_state_e       state_q, state_d;
   logic             sel_q, rto_q, fto_q;
   logic             settle_exp, rise_exp, fall_exp;
   logic             ack_cur, active, fin, last, accept;
   logic [PHY_W-1:0] cur_phy;
   logic [AW-1:0]    list_addr;
   logic [DW-1:0]    list_data;

   crw_timer #(.LIMIT(SETTLE_CYC)) u_settle (
      .clk(clk), .rst_n(rst_n), .run_i(state_q == ST_SETTLE), .expired_o(settle_exp));
   crw_timer #(.LIMIT(RISE_TMO_CYC)) u_rise (
      .clk(clk), .rst_n(rst_n), .run_i(state_q == ST_WAIT_HI), .expired_o(rise_exp));
   crw_timer #(.LIMIT(FALL_TMO_CYC)) u_fall (
      .clk(clk), .rst_n(rst_n), .run_i(state_q == ST_WAIT_LO), .expired_o(fall_exp));

   crw_list #(
      .N_PHY(N_PHY), .N_LANE(N_LANE), .AW(AW), .DW(DW),
      .BASE(LANE_BASE), .STRIDE(LANE_STRIDE), .WVAL(WR_VALUE)
   ) u_list (
      .clk(clk), .rst_n(rst_n), .rewind_i(accept), .step_i(fin),
      .phy_o(cur_phy), .addr_o(list_addr), .data_o(list_data), .last_o(last));

   assign accept  = (state_q == ST_IDLE) && start_i;
   assign ack_cur = phy_ack_i[cur_phy];
   assign fin     = (state_q == ST_WAIT_LO) && (!ack_cur || fall_exp);
   assign active  = (state_q == ST_SETUP) || (state_q == ST_WAIT_HI) ||
                    (state_q == ST_WAIT_LO);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:    if (start_i) state_d = ST_SETTLE;
         ST_SETTLE:  if (settle_exp) state_d = ST_SETUP;
         ST_SETUP:   state_d = ST_WAIT_HI;
         ST_WAIT_HI: if (ack_cur || rise_exp) state_d = ST_WAIT_LO;
         ST_WAIT_LO: if (fin) state_d = last ? ST_DONE : ST_SETUP;
         ST_DONE:    state_d = ST_IDLE;
         default:    state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         sel_q   <= 1'b0;
         rto_q   <= 1'b0;
         fto_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         sel_q   <= sel_q | accept;
         rto_q   <= rto_q | ((state_q == ST_WAIT_HI) && !ack_cur && rise_exp);
         fto_q   <= fto_q | ((state_q == ST_WAIT_LO) && ack_cur && fall_exp);
      end
   end

   for (genvar p = 0; p < N_PHY; p++) begin : g_phy
      logic hit;
      assign hit                         = active && (cur_phy == PHY_W'(p));
      assign phy_sel_o[p]                = sel_q;
      assign phy_addr_o[p*AW +: AW]      = hit ? list_addr : '0;
      assign phy_wdata_o[p*DW +: DW]     = hit ? list_data : '0;
      assign phy_wen_o[p]                = hit && (state_q == ST_WAIT_HI);
   end

   assign done_o     = (state_q == ST_DONE);
   assign rise_tmo_o = rto_q;
   assign fall_tmo_o = fto_q;

   p_sel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (&phy_sel_o) |=> (&phy_sel_o));
   p_setup_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(|phy_wen_o) |-> $stable(phy_addr_o) && (phy_addr_o != '0));
   p_wen_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|(phy_wen_o & phy_ack_i)) |=> (phy_wen_o == '0));
   p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(phy_wen_o));
   p_rise_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rise_tmo_o |=> rise_tmo_o);
   p_fall_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fall_tmo_o |=> fall_tmo_o);
   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

endmodule

// File: tb/sim_phy_crw_master.sv
module sim_phy_crw_master;
   localparam int SETTLE = 10;
   localparam int RISE   = 20;
   localparam int FALL   = 16;
   localparam int DVAL   = 16'h0E21;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        done;
   logic [1:0]  sel;
   logic [31:0] addr;
   logic [31:0] wdata;
   logic [1:0]  wen;
   logic [1:0]  ack = 2'b00;
   logic        rto, fto;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   phy_crw_master #(
      .SETTLE_CYC(SETTLE), .RISE_TMO_CYC(RISE), .FALL_TMO_CYC(FALL)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start), .done_o(done),
      .phy_sel_o(sel), .phy_addr_o(addr), .phy_wdata_o(wdata),
      .phy_wen_o(wen), .phy_ack_i(ack), .rise_tmo_o(rto), .fall_tmo_o(fto));

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // behavioural reference: phase 0 idle,1 settle,2 setup,3 wait-rise,4 wait-fall,5 done
   int m_ph, m_cnt, m_idx;
   bit m_sel, m_rto, m_fto;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ph = 0; m_cnt = 0; m_idx = 0; m_sel = 0; m_rto = 0; m_fto = 0;
      end else begin
         case (m_ph)
            0: if (start) begin m_ph = 1; m_cnt = 0; m_sel = 1; m_idx = 0; end
            1: begin m_cnt++; if (m_cnt == SETTLE) m_ph = 2; end
            2: begin m_ph = 3; m_cnt = 0; end
            3: begin
               m_cnt++;
               if (ack[m_idx/4]) begin m_ph = 4; m_cnt = 0; end
               else if (m_cnt == RISE) begin m_rto = 1; m_ph = 4; m_cnt = 0; end
            end
            4: begin
               m_cnt++;
               if (!ack[m_idx/4] || m_cnt == FALL) begin
                  if (ack[m_idx/4]) m_fto = 1;
                  m_cnt = 0;
                  if (m_idx == 7) m_ph = 5;
                  else begin m_idx++; m_ph = 2; end
               end
            end
            default: m_ph = 0;
         endcase
      end
   end

   // responder tables, monitor state
   int hi_dly[8];
   int lo_dly[8];
   int rcnt[2];
   int wcnt = 0;
   int done_cnt = 0;
   bit prev_wen = 0;
   logic [31:0] prev_addr = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         for (int p = 0; p < 2; p++) begin
            automatic bit act = (m_ph >= 2 && m_ph <= 4) && (m_idx / 4 == p);
            automatic int ea  = act ? 32'h1008 + 32'h100 * (m_idx % 4) : 0;
            automatic int ed  = act ? DVAL : 0;
            automatic bit ew  = (m_ph == 3) && (m_idx / 4 == p);
            chk(addr[p*16 +: 16] == 16'(ea), $sformatf("R6 R5 addr phy%0d", p), addr[p*16 +: 16], ea);
            chk(wdata[p*16 +: 16] == 16'(ed), $sformatf("R6 R5 data phy%0d", p), wdata[p*16 +: 16], ed);
            chk(wen[p] == ew, $sformatf("R4 R5 strobe phy%0d", p), wen[p], ew);
         end
         chk(sel == {2{m_sel}}, "R2 select", sel, {2{m_sel}});
         chk(done == (m_ph == 5), "R10 done", done, m_ph == 5);
         chk(rto == m_rto, "R8 rise flag", rto, m_rto);
         chk(fto == m_fto, "R9 fall flag", fto, m_fto);
         if ((|wen) && !prev_wen) begin
            chk(addr == prev_addr && addr != 0, "R3 setup before strobe", addr, prev_addr);
            if (wcnt < 8) begin
               chk(wen[wcnt/4] == 1'b1, "R7 order phy", wen, 1 << (wcnt/4));
               chk(addr[(wcnt/4)*16 +: 16] == 16'(32'h1008 + 32'h100 * (wcnt % 4)),
                   "R7 order lane", addr, 32'h1008 + 32'h100 * (wcnt % 4));
            end
            wcnt++;
         end
         if (done) done_cnt++;
      end
      prev_wen  = |wen;
      prev_addr = addr;
      for (int p = 0; p < 2; p++) begin
         automatic int wi = (wcnt > 0) ? (wcnt - 1) % 8 : 0;
         if (!rst_n) begin ack[p] = 1'b0; rcnt[p] = 0; end
         else if (wen[p] && !ack[p]) begin
            if (rcnt[p] >= hi_dly[wi]) begin ack[p] = 1'b1; rcnt[p] = 0; end
            else rcnt[p]++;
         end else if (!wen[p] && ack[p]) begin
            if (rcnt[p] >= lo_dly[wi]) begin ack[p] = 1'b0; rcnt[p] = 0; end
            else rcnt[p]++;
         end else rcnt[p] = 0;
      end
   end

   task automatic set_dly(input int h0, input int l0);
      for (int i = 0; i < 8; i++) begin hi_dly[i] = h0; lo_dly[i] = l0; end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      chk(sel == 0 && addr == 0 && wdata == 0 && wen == 0 && !done && !rto && !fto,
          "R1 reset outputs", {sel, wen, done, rto, fto}, 0);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk(sel == 0 && addr == 0 && wen == 0 && !done, "R1 after release", {sel, wen, done}, 0);
   endtask

   task automatic run_seq(input bit busy_start);
      int k = 0;
      int d0;
      @(negedge clk);
      wcnt = 0;
      d0 = done_cnt;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      #1;
      k = 1;
      while (addr == 0 && k < 100) begin @(negedge clk); #1; k++; end
      chk(k == SETTLE + 1, "R2 settle length", k, SETTLE + 1);
      if (busy_start) begin
         @(negedge clk); start = 1'b1;
         @(negedge clk); start = 1'b0;
      end
      k = 0;
      while (done_cnt == d0 && k < 3000) begin @(negedge clk); #1; k++; end
      repeat (5) @(negedge clk);
      #1;
      chk(done_cnt == d0 + 1, "R10 R11 single done", done_cnt - d0, 1);
      chk(wcnt == 8, "R7 write count", wcnt, 8);
   endtask

   initial begin : wdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      set_dly(0, 0);
      do_reset();
      // R4 R6 R11: varied delays plus a start pulse while busy
      hi_dly = '{1, 0, 2, 3, 0, 1, 4, 2};
      lo_dly = '{0, 1, 3, 0, 2, 1, 0, 5};
      run_seq(1'b1);
      chk(!rto && !fto, "R8 R9 no timeout", {rto, fto}, 0);
      // zero-delay acknowledge
      set_dly(0, 0);
      run_seq(1'b0);
      // R8: write 5 never acknowledged
      hi_dly[5] = 1000;
      run_seq(1'b0);
      chk(rto == 1 && fto == 0, "R8 rise timeout flag", {rto, fto}, 2'b10);
      do_reset();
      chk(!rto && !fto, "R12 cleared by reset", {rto, fto}, 0);
      // R9: write 2 acknowledge held high past limit
      set_dly(1, 1);
      lo_dly[2] = FALL + 6;
      run_seq(1'b0);
      chk(fto == 1 && rto == 0, "R9 fall timeout flag", {rto, fto}, 2'b01);
      // R12: rerun keeps the flag
      set_dly(2, 2);
      run_seq(1'b0);
      chk(fto == 1, "R12 flag sticky over rerun", fto, 1);
      do_reset();
      chk(!fto, "R12 flag cleared", fto, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule